// File: doc/BRIEF.md
# Dual-Port Parallel Interface Adapter

This block connects a processor bus to two 8-bit parallel ports, called A and B. Each port has an output latch and a direction register. Each port also samples its external input bus on every clock and has a six-bit control register. A processor reaches all of this through four register offsets, using separate read and write strobes and an 8-bit data bus. At each data offset, a control bit selects whether the location is the port itself or its direction register.

Each port also has two event lines, C1 and C2. Each line has an interrupt flag that is set by a level change in the edge direction chosen in the control register. The pins are synchronized before edge detection. A flag stays pending until software reads the data location of that port. The flags appear in the top two bits of the control register when it is read. A per-port interrupt output combines each flag with its enable bit.

Top module: `tpa_top`

## Requirements
- R1: Offset 0 is port A data or direction, offset 1 is control A, offset 2 is port B data or direction, and offset 3 is control B. An access at one offset never changes the state behind another offset.
- R2: At a data offset, control bit 2 = 1 selects the port (output latch on write, pin view on read). Bit 2 = 0 selects the direction register for both reads and writes. The direction and latch buses always show the stored direction register and output latch.
- R3: A write to a control register keeps only data bits 5:0.
- R4: A control read returns the stored six bits in 5:0. Bit 7 is 1 while the C1 flag is pending. Bit 6 is 1 while the C2 flag is pending and control bit 5 is 0.
- R5: A port read returns (sampled input AND NOT direction) OR (output latch AND direction). The input is sampled into a register on every clock.
- R6: A port read (bit 2 = 1) clears both flags of that port. A direction read clears nothing. If a flag is set and cleared in the same cycle, it ends up set.
- R7: The C1 flag is set only when the synchronized level changes and the new level equals control bit 1 (1 = rising, 0 = falling). A steady level never sets it.
- R8: The C2 flag follows the same rule using control bit 4. No C2 transition sets it while control bit 5 = 1 (C2 acting as an output).
- R9: The interrupt output of a port is registered and equals (C1 flag AND bit 0) OR (C2 flag AND bit 3 AND NOT bit 5).
- R10: Reset (synchronous, active high) clears the latches, sampled inputs, direction and control registers, line state, all flags, the interrupt outputs and the read data.
- R11: A pin change driven before clock edge k sets its flag at edge k+2, after two synchronizer flops.
- R12: Read data is registered. It updates at the edge where the read strobe is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A external input bus |
| pa_c1 | input | 1 | Port A C1 event pin |
| pa_c2 | input | 1 | Port A C2 event pin |
| pa_out | output | 8 | Port A output latch |
| pa_dir | output | 8 | Port A direction register (1 = output) |
| irq_a | output | 1 | Port A interrupt request |
| pb_in | input | 8 | Port B external input bus |
| pb_c1 | input | 1 | Port B C1 event pin |
| pb_c2 | input | 1 | Port B C2 event pin |
| pb_out | output | 8 | Port B output latch |
| pb_dir | output | 8 | Port B direction register (1 = output) |
| irq_b | output | 1 | Port B interrupt request |

## Verification
The case that matters is a port read that clears the flags arriving at the same clock edge as a synchronized pin edge that sets one. The bench changes a C1 pin and then places the port read strobe exactly two edges later, so both events land on the same edge. It then reads the control register and requires bit 7 to be set, with the interrupt output still high. A behavioural model that updates at every edge confirms the exact cycle, and neighbouring reads show the flag absent one edge earlier and present one edge later.

// File: rtl/tpa_pkg.sv
package tpa_pkg;
  localparam int CTL_W      = 6;
  localparam int B_C1_EN    = 0;
  localparam int B_C1_RISE  = 1;
  localparam int B_PORT_SEL = 2;
  localparam int B_C2_EN    = 3;
  localparam int B_C2_RISE  = 4;
  localparam int B_C2_OUT   = 5;
  localparam int NUM_PORTS  = 2;
  localparam int NUM_LINES  = 2;
endpackage

// File: rtl/tpa_line_sync.sv
module tpa_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl_new,
  output logic changed
);
  logic [STAGES-1:0] sh_q;
  logic              lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      lvl_q <= 1'b0;
    end else begin
      sh_q  <= {sh_q[STAGES-2:0], pin};
      lvl_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_new = sh_q[STAGES-1];
  assign changed = sh_q[STAGES-1] ^ lvl_q;
endmodule

// File: rtl/tpa_port.sv
module tpa_port
  import tpa_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_data,
  input  logic          wr_ctl,
  input  logic          rd_data,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  input  logic          c1_pin,
  input  logic          c2_pin,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] ddr_q,
  output logic [DW-1:0] data_view,
  output logic [DW-1:0] ctl_view,
  output logic          irq_q
);
  logic [DW-1:0]        in_q;
  logic [CTL_W-1:0]     ctl_q, ctl_d;
  logic                 f1_q, f2_q, f1_d, f2_d;
  logic [NUM_LINES-1:0] line_pin, line_new, line_chg;
  logic                 c1_hit, c2_hit, clr_req;

  assign line_pin = {c2_pin, c1_pin};

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    tpa_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .pin     (line_pin[l]),
      .lvl_new (line_new[l]),
      .changed (line_chg[l])
    );
  end

  assign c1_hit  = line_chg[0] && (line_new[0] == ctl_q[B_C1_RISE]);
  assign c2_hit  = line_chg[1] && (line_new[1] == ctl_q[B_C2_RISE]) && !ctl_q[B_C2_OUT];
  assign clr_req = rd_data && ctl_q[B_PORT_SEL];

  // a set arriving with a clear wins
  assign f1_d  = c1_hit | (f1_q & ~clr_req);
  assign f2_d  = c2_hit | (f2_q & ~clr_req);
  assign ctl_d = wr_ctl ? wdata[CTL_W-1:0] : ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      ddr_q <= '0;
      in_q  <= '0;
      ctl_q <= '0;
      f1_q  <= 1'b0;
      f2_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      in_q  <= pin_in;
      ctl_q <= ctl_d;
      f1_q  <= f1_d;
      f2_q  <= f2_d;
      irq_q <= (f1_d & ctl_d[B_C1_EN]) |
               (f2_d & ctl_d[B_C2_EN] & ~ctl_d[B_C2_OUT]);
      if (wr_data) begin
        if (ctl_q[B_PORT_SEL]) out_q <= wdata;
        else                   ddr_q <= wdata;
      end
    end
  end

  always_comb begin
    if (ctl_q[B_PORT_SEL]) data_view = (in_q & ~ddr_q) | (out_q & ddr_q);
    else                   data_view = ddr_q;
    ctl_view              = '0;
    ctl_view[CTL_W-1:0]   = ctl_q;
    ctl_view[DW-1]        = f1_q;
    ctl_view[DW-2]        = f2_q & ~ctl_q[B_C2_OUT];
  end

  // R6: a port read with no new edge leaves C1 clear
  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !c1_hit) |=> !f1_q);
  // R7: no qualified change, no C1 flag
  a_r7_no_spurious_c1: assert property (@(posedge clk) disable iff (rst)
    (!c1_hit && !f1_q) |=> !f1_q);
  // R8: C2 in output mode never raises its flag
  a_r8_c2_output_quiet: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[B_C2_OUT] && !f2_q) |=> !f2_q);
  // R9: both enables off keeps the request low
  a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
    (!wr_ctl && !ctl_q[B_C1_EN] && !ctl_q[B_C2_EN]) |=> !irq_q);
endmodule

// File: rtl/tpa_top.sv
module tpa_top
  import tpa_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pa_in,
  input  logic          pa_c1,
  input  logic          pa_c2,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_dir,
  output logic          irq_a,
  input  logic [DW-1:0] pb_in,
  input  logic          pb_c1,
  input  logic          pb_c2,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_dir,
  output logic          irq_b
);
  logic [DW-1:0] p_in   [NUM_PORTS];
  logic [DW-1:0] p_out  [NUM_PORTS];
  logic [DW-1:0] p_dir  [NUM_PORTS];
  logic [DW-1:0] p_dv   [NUM_PORTS];
  logic [DW-1:0] p_cv   [NUM_PORTS];
  logic          p_c1   [NUM_PORTS];
  logic          p_c2   [NUM_PORTS];
  logic          p_irq  [NUM_PORTS];

  // offset bit 1 picks the port, bit 0 picks control over data
  logic sel_port, sel_ctl;
  assign sel_port = bus_addr[1];
  assign sel_ctl  = bus_addr[0];

  assign p_in[0] = pa_in;  assign p_c1[0] = pa_c1;  assign p_c2[0] = pa_c2;
  assign p_in[1] = pb_in;  assign p_c1[1] = pb_c1;  assign p_c2[1] = pb_c2;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    localparam logic PIDX = 1'(g);
    logic hit;
    assign hit = (sel_port == PIDX);
    tpa_port #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_port (
      .clk       (clk),
      .rst       (rst),
      .wr_data   (bus_wr && hit && !sel_ctl),
      .wr_ctl    (bus_wr && hit && sel_ctl),
      .rd_data   (bus_rd && hit && !sel_ctl),
      .wdata     (bus_wdata),
      .pin_in    (p_in[g]),
      .c1_pin    (p_c1[g]),
      .c2_pin    (p_c2[g]),
      .out_q     (p_out[g]),
      .ddr_q     (p_dir[g]),
      .data_view (p_dv[g]),
      .ctl_view  (p_cv[g]),
      .irq_q     (p_irq[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= sel_ctl ? p_cv[sel_port] : p_dv[sel_port];
  end

  assign pa_out = p_out[0];
  assign pa_dir = p_dir[0];
  assign irq_a  = p_irq[0];
  assign pb_out = p_out[1];
  assign pb_dir = p_dir[1];
  assign irq_b  = p_irq[1];

  // R12: read data holds while no read is strobed
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R1: a write at port A offsets leaves port B buses unchanged
  a_r1_port_isolation: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !sel_port) |=> ($stable(pb_out) && $stable(pb_dir)));
endmodule

// File: tb/test_tpa_top.sv
module test_tpa_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = '0, pb_in = '0;
  logic       pa_c1 = 0, pa_c2 = 0, pb_c1 = 0, pb_c2 = 0;
  logic [7:0] pa_out, pa_dir, pb_out, pb_dir;
  logic       irq_a, irq_b;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tpa_top i_tpa_top (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_c1(pa_c1), .pa_c2(pa_c2), .pa_out(pa_out), .pa_dir(pa_dir), .irq_a(irq_a),
    .pb_in(pb_in), .pb_c1(pb_c1), .pb_c2(pb_c2), .pb_out(pb_out), .pb_dir(pb_dir), .irq_b(irq_b)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_out [2] = '{default:0};
  logic [7:0] m_ddr [2] = '{default:0};
  logic [7:0] m_in  [2] = '{default:0};
  logic [5:0] m_ctl [2] = '{default:0};
  bit   m_irq [2];
  bit   m_flag [2][2];
  bit   m_pipe [2][2][$];   // per port, per line: pin history, oldest first
  bit   m_lvl  [2][2];
  logic [7:0] m_rdata = '0;

  always @(posedge clk) begin
    bit pins [2][2];
    bit hit  [2][2];
    bit clr  [2];
    bit synced;
    int p;
    pins[0][0] = pa_c1; pins[0][1] = pa_c2; pins[1][0] = pb_c1; pins[1][1] = pb_c2;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_out[i] = 0; m_ddr[i] = 0; m_in[i] = 0; m_ctl[i] = 0; m_irq[i] = 0;
        for (int j = 0; j < 2; j++) begin
          m_flag[i][j] = 0; m_lvl[i][j] = 0;
          m_pipe[i][j] = {1'b0, 1'b0};
        end
      end
      m_rdata = 0;
    end else begin
      p = int'(bus_addr[1]);
      if (bus_rd) begin
        if (bus_addr[0])
          m_rdata = {m_flag[p][0], m_flag[p][1] && !m_ctl[p][5], m_ctl[p]};
        else if (m_ctl[p][2])
          m_rdata = (m_in[p] & ~m_ddr[p]) | (m_out[p] & m_ddr[p]);
        else
          m_rdata = m_ddr[p];
      end
      for (int i = 0; i < 2; i++) begin
        clr[i] = bus_rd && !bus_addr[0] && (p == i) && m_ctl[i][2];
        for (int j = 0; j < 2; j++) begin
          synced = m_pipe[i][j][0];
          hit[i][j] = (synced != m_lvl[i][j]) &&
                      (synced == (j == 0 ? m_ctl[i][1] : m_ctl[i][4])) &&
                      !(j == 1 && m_ctl[i][5]);
          m_lvl[i][j] = synced;
          void'(m_pipe[i][j].pop_front());
          m_pipe[i][j].push_back(pins[i][j]);
          m_flag[i][j] = hit[i][j] || (m_flag[i][j] && !clr[i]);
        end
      end
      if (bus_wr) begin
        if (bus_addr[0]) m_ctl[p] = bus_wdata[5:0];
        else if (m_ctl[p][2]) m_out[p] = bus_wdata;
        else m_ddr[p] = bus_wdata;
      end
      m_in[0] = pa_in; m_in[1] = pb_in;
      for (int i = 0; i < 2; i++)
        m_irq[i] = (m_flag[i][0] && m_ctl[i][0]) ||
                   (m_flag[i][1] && m_ctl[i][3] && !m_ctl[i][5]);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 port A buses", {pa_out, pa_dir}, {m_out[0], m_ddr[0]});
      chk("R2 port B buses", {pb_out, pb_dir}, {m_out[1], m_ddr[1]});
      chk("R9 R11 irq", {30'd0, irq_b, irq_a}, {30'd0, m_irq[1], m_irq[0]});
      chk("R12 rdata", {24'd0, bus_rdata}, {24'd0, m_rdata});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    chk(tag, {24'd0, bus_rdata}, {24'd0, exp});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R10: reset state
    chk("R10 reset outputs", {pa_out, pa_dir, pb_out, pb_dir}, 32'd0);
    rst = 0;
    rd(2'd1, 8'h00, "R10 ctrl A after reset");

    // R2 / R5: direction vs port access
    pa_in = 8'h3C;
    wr(2'd0, 8'hF0);
    chk("R2 dir write", {24'd0, pa_dir}, 32'hF0);
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h5A);
    chk("R2 latch write", {16'd0, pa_out, pa_dir}, 32'h5AF0);
    rd(2'd0, 8'h5C, "R5 port A mixed read");
    wr(2'd1, 8'h00);
    rd(2'd0, 8'hF0, "R2 direction read");

    // R3 / R1: control masking and offset isolation
    wr(2'd3, 8'hFF);
    rd(2'd3, 8'h3F, "R3 ctrl B masked");
    wr(2'd2, 8'h81);
    chk("R1 port B latch", {24'd0, pb_out}, 32'h81);
    rd(2'd1, 8'h00, "R1 ctrl A untouched");

    // R7 / R4 / R9 / R6 on C1 of port A
    wr(2'd1, 8'h07);
    pa_c1 = 1; idle(4);
    chk("R9 irq A on C1", {31'd0, irq_a}, 32'd1);
    rd(2'd1, 8'h87, "R7 R4 C1 flag shown");
    rd(2'd0, 8'h5C, "R5 port read");
    chk("R6 irq cleared", {31'd0, irq_a}, 32'd0);
    rd(2'd1, 8'h07, "R6 flag cleared");
    pa_c1 = 0; idle(4);
    rd(2'd1, 8'h07, "R7 wrong edge ignored");
    idle(4);
    rd(2'd1, 8'h07, "R7 steady level ignored");

    // R8: C2 in output mode, then input mode
    wr(2'd1, 8'h3F);
    pa_c2 = 1; idle(4); pa_c2 = 0; idle(4);
    rd(2'd1, 8'h3F, "R8 C2 output ignores edges");
    chk("R8 no irq", {31'd0, irq_a}, 32'd0);
    wr(2'd1, 8'h1C);
    pa_c2 = 1; idle(4);
    rd(2'd1, 8'h5C, "R8 R4 C2 flag shown");
    chk("R9 irq A on C2", {31'd0, irq_a}, 32'd1);
    wr(2'd1, 8'h3C);
    rd(2'd1, 8'h3C, "R4 C2 flag hidden in output mode");
    chk("R9 C2 masked by output", {31'd0, irq_a}, 32'd0);
    wr(2'd1, 8'h1C);
    chk("R9 pending flag returns", {31'd0, irq_a}, 32'd1);
    rd(2'd0, 8'h5C, "R6 port read clears C2");
    chk("R6 irq low", {31'd0, irq_a}, 32'd0);

    // R11: synchronizer latency on port B C1
    wr(2'd3, 8'h07);
    pb_c1 = 1;
    rd(2'd3, 8'h07, "R11 flag not yet at edge 2");
    rd(2'd3, 8'h87, "R11 flag present by edge 4");
    rd(2'd2, 8'h00, "R6 clear port B");
    pb_c1 = 0; idle(4);

    // R6: set and clear on the same edge, set wins
    pb_c1 = 1;
    @(negedge clk);
    @(negedge clk); bus_addr = 2'd2; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    rd(2'd3, 8'h87, "R6 set wins over same-cycle clear");
    chk("R6 irq B stays", {31'd0, irq_b}, 32'd1);

    // R10: reset mid-run
    pb_c1 = 0; pa_in = 0;
    @(negedge clk); rst = 1;
    idle(2);
    chk("R10 buses cleared", {pa_out, pa_dir, pb_out, pb_dir}, 32'd0);
    chk("R10 irq and rdata", {22'd0, irq_a, irq_b, bus_rdata}, 32'd0);
    rst = 0;
    rd(2'd3, 8'h00, "R10 ctrl B cleared");
    idle(6);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule